// File: doc/BRIEF.md
# Single-Clock FIFO with Selectable Read Presentation

This block is a single-clock FIFO. A parameter selects how its read side presents data. In the pull mode, the consumer asks for each word, including the first one after the FIFO was empty. A request accepted on one clock edge puts the word on the read data output after that edge.

In the push mode, the oldest stored word moves to the output without any request, and a valid flag marks it. The read enable then only acknowledges the shown word and lets the next one move forward. Once a word is on the output, the two modes behave alike: a read enable exchanges it for the next stored word. They differ only in how the first word after empty reaches the output.

The FIFO refuses a write while it is full and a read while it is empty. Each refusal sets a sticky error flag, which only reset clears. Storage depth must be a power of two and at least two. The read and write pointers each carry one extra wrap bit, so a full FIFO can be told apart from an empty one.

Top module: `dm_fifo`

## Requirements
- R1: After reset (active-low `rstN`), `empty`=1, `full`=0, `rdValid`=0, `rdData`=0, `overflow`=0 and `underflow`=0.
- R2: With `FALL_THROUGH`=0, a word written into an empty FIFO does not reach `rdData` and does not raise `rdValid` until a read enable is accepted.
- R3: With `FALL_THROUGH`=0, a read enable sampled while `empty`=0 loads the oldest word into `rdData` at that clock edge and raises `rdValid` for that one cycle. Otherwise `rdValid` is 0 and `rdData` holds its value.
- R4: With `FALL_THROUGH`=1, a word written into an empty FIFO appears on `rdData` with `rdValid`=1 after the second clock edge that follows the write edge, with no read enable.
- R5: With `FALL_THROUGH`=1, `empty` equals the inverse of `rdValid`. The shown word stays stable until a read enable sampled with `rdValid`=1 replaces it with the next stored word, or drops `rdValid` if no word is stored.
- R6: In both modes, words leave in the order they were written.
- R7: `full` rises when the storage array holds `DEPTH` words. In the push mode the output stage holds one more word on top of these, so the total capacity is `DEPTH`+1.
- R8: A write sampled while `full`=1 stores nothing and sets `overflow`, which stays set until reset.
- R9: A read enable sampled while `empty`=1 changes no output data and sets `underflow`, which stays set until reset.
- R10: When read and write enables are both high, the `full` and `empty` flags sampled at that edge decide whether each is accepted, each on its own. At empty the write is kept. At full the read is kept and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write enable |
| wrData | input | DATA_W | Data to store |
| full | output | 1 | Storage array holds DEPTH words |
| rdEn | input | 1 | Read request (pull mode) or acknowledge (push mode) |
| rdData | output | DATA_W | Read data register |
| rdValid | output | 1 | A word is being presented on rdData |
| empty | output | 1 | No word is available to read |
| overflow | output | 1 | Sticky: a write was refused |
| underflow | output | 1 | Sticky: a read was refused |

## Verification
In the pull mode, a read accepted at one edge shows its data and a `rdValid` pulse right after that same edge. In the push mode, a write into an empty FIFO shows its word after the second edge, because the word passes through storage and then the output stage. Flags and sticky errors change at the edge that sampled the causing enables.

The bench drives inputs on the falling edge and advances a queue-based model of each mode right after the rising edge. It compares every output at the next falling edge, so each expected value is taken exactly one edge after its stimulus. Directed phases cover the first word after empty in each mode, fill past full, drain past empty, and simultaneous enables at both limits. A long random phase follows.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic memWrite;  // store wrData at wrAddr
    logic outLoad;   // copy word at rdAddr into the read register
  } dmfStrobes_t;
endpackage

// File: rtl/dmf_ctrl.sv
module dmf_ctrl
  import dmf_pkg::*;
#(
  parameter int DEPTH        = 8,
  parameter bit FALL_THROUGH = 1'b0,
  localparam int AW          = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  output dmfStrobes_t   strobes,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          full,
  output logic          empty,
  output logic          rdValid,
  output logic          overflow,
  output logic          underflow
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wrPtr, rdPtr;
  logic          memEmpty, memFull;
  logic          validQ, validNext;
  logic          outLoad, emptyFlag;
  logic          ovfQ, unfQ;

  assign memEmpty = (wrPtr == rdPtr);
  assign memFull  = (wrPtr[AW] != rdPtr[AW]) && (wrPtr[AW-1:0] == rdPtr[AW-1:0]);

  generate
    if (FALL_THROUGH) begin : g_push
      // head moves forward whenever the output stage is free or acknowledged
      assign outLoad   = !memEmpty && (!validQ || rdEn);
      assign validNext = outLoad || (validQ && !rdEn);
      assign emptyFlag = !validQ;
    end else begin : g_pull
      assign outLoad   = rdEn && !memEmpty;
      assign validNext = outLoad;
      assign emptyFlag = memEmpty;
    end
  endgenerate

  assign strobes.memWrite = wrEn && !memFull;
  assign strobes.outLoad  = outLoad;
  assign wrAddr = wrPtr[AW-1:0];
  assign rdAddr = rdPtr[AW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      validQ <= 1'b0;
      ovfQ   <= 1'b0;
      unfQ   <= 1'b0;
    end else begin
      if (strobes.memWrite) wrPtr <= wrPtr + 1'b1;
      if (outLoad)          rdPtr <= rdPtr + 1'b1;
      validQ <= validNext;
      if (wrEn && memFull)   ovfQ <= 1'b1;
      if (rdEn && emptyFlag) unfQ <= 1'b1;
    end
  end

  assign full      = memFull;
  assign empty     = emptyFlag;
  assign rdValid   = validQ;
  assign overflow  = ovfQ;
  assign underflow = unfQ;
endmodule

// File: rtl/dmf_datapath.sv
module dmf_datapath
  import dmf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmfStrobes_t       strobes,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] rdDataQ;

  always_ff @(posedge clk) begin
    if (strobes.memWrite) store[wrAddr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rdDataQ <= '0;
    else if (strobes.outLoad) rdDataQ <= store[rdAddr];
  end

  assign rdData = rdDataQ;
endmodule

// File: rtl/dm_fifo.sv
module dm_fifo
  import dmf_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int DEPTH        = 8,
  parameter bit FALL_THROUGH = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              full,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              empty,
  output logic              overflow,
  output logic              underflow
);
  localparam int AW = $clog2(DEPTH);

  dmfStrobes_t   strobes;
  logic [AW-1:0] wrAddr, rdAddr;

  dmf_ctrl #(.DEPTH(DEPTH), .FALL_THROUGH(FALL_THROUGH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .strobes(strobes),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .full(full), .empty(empty),
    .rdValid(rdValid), .overflow(overflow), .underflow(underflow)
  );

  dmf_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/dmf_checker.sv
module dmf_checker #(
  parameter int DATA_W       = 8,
  parameter bit FALL_THROUGH = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic              full,
  input logic              empty,
  input logic              rdValid,
  input logic [DATA_W-1:0] rdData,
  input logic              overflow,
  input logic              underflow
);
  AST_PULL_NO_SELF_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    (!FALL_THROUGH && empty) |=> !rdValid); // R2
  AST_PULL_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (!FALL_THROUGH && rdValid) |-> ($past(rdEn) && !$past(empty))); // R3
  AST_PULL_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!FALL_THROUGH && !rdEn) |=> $stable(rdData)); // R3
  AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (FALL_THROUGH && rdValid && !rdEn) |=> (rdValid && $stable(rdData))); // R5
  AST_PUSH_EMPTY_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    FALL_THROUGH |-> (empty == !rdValid)); // R5
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && full) |=> overflow); // R8
  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow); // R8
  AST_UNDERFLOW_SET: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && empty) |=> underflow); // R9
  AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> underflow); // R9
endmodule

bind dm_fifo dmf_checker #(.DATA_W(DATA_W), .FALL_THROUGH(FALL_THROUGH)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .full(full), .empty(empty),
  .rdValid(rdValid), .rdData(rdData), .overflow(overflow), .underflow(underflow)
);

// File: tb/dm_fifo_tb.sv
module dm_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int D  = 8;
  localparam int WATCHDOG_CYCLES = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [DW-1:0] wrData = '0;

  logic sFull, sEmpty, sValid, sOvf, sUnf;
  logic [DW-1:0] sData;
  logic fFull, fEmpty, fValid, fOvf, fUnf;
  logic [DW-1:0] fData;

  int compared = 0, mismatched = 0;

  // models
  logic [DW-1:0] mq[$];
  logic [DW-1:0] mData = '0;
  bit mValid = 0, mOvf = 0, mUnf = 0;
  logic [DW-1:0] fq[$];
  logic [DW-1:0] mfData = '0;
  bit mfValid = 0, mfOvf = 0, mfUnf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dm_fifo #(.DATA_W(DW), .DEPTH(D), .FALL_THROUGH(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .full(sFull),
    .rdEn(rdEn), .rdData(sData), .rdValid(sValid), .empty(sEmpty),
    .overflow(sOvf), .underflow(sUnf));

  dm_fifo #(.DATA_W(DW), .DEPTH(D), .FALL_THROUGH(1'b1)) u_dut_ft (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .full(fFull),
    .rdEn(rdEn), .rdData(fData), .rdValid(fValid), .empty(fEmpty),
    .overflow(fOvf), .underflow(fUnf));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic modelStep();
    bit ra, wa, ld, nv;
    // pull mode
    wa = wrEn && (mq.size() < D);
    ra = rdEn && (mq.size() > 0);
    if (wrEn && mq.size() == D) mOvf = 1;
    if (rdEn && mq.size() == 0) mUnf = 1;
    mValid = ra;
    if (ra) mData = mq.pop_front();
    if (wa) mq.push_back(wrData);
    // push mode
    wa = wrEn && (fq.size() < D);
    if (wrEn && fq.size() == D) mfOvf = 1;
    if (rdEn && !mfValid) mfUnf = 1;
    ld = (fq.size() > 0) && (!mfValid || rdEn);
    nv = ld || (mfValid && !rdEn);
    if (ld) mfData = fq.pop_front();
    if (wa) fq.push_back(wrData);
    mfValid = nv;
  endtask

  task automatic compareAll();
    check("R3 R6 pull rdData", 32'(sData), 32'(mData));
    check("R2 R3 pull rdValid", 32'(sValid), 32'(mValid));
    check("R9 R10 pull empty", 32'(sEmpty), 32'(mq.size() == 0));
    check("R7 R10 pull full", 32'(sFull), 32'(mq.size() == D));
    check("R8 pull overflow", 32'(sOvf), 32'(mOvf));
    check("R9 pull underflow", 32'(sUnf), 32'(mUnf));
    check("R4 R6 push rdData", 32'(fData), 32'(mfData));
    check("R4 R5 push rdValid", 32'(fValid), 32'(mfValid));
    check("R5 push empty", 32'(fEmpty), 32'(!mfValid));
    check("R7 R10 push full", 32'(fFull), 32'(fq.size() == D));
    check("R8 push overflow", 32'(fOvf), 32'(mfOvf));
    check("R9 push underflow", 32'(fUnf), 32'(mfUnf));
  endtask

  // one cycle: drive at falling edge, model after rising edge, compare at next falling edge
  task automatic cycle(input bit w, input bit r, input logic [DW-1:0] d);
    wrEn = w; rdEn = r; wrData = d;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  logic [DW-1:0] seq = 8'h10;

  initial begin
    fork
      begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 pull empty", 32'(sEmpty), 1);
    check("R1 pull full", 32'(sFull), 0);
    check("R1 pull rdValid", 32'(sValid), 0);
    check("R1 pull rdData", 32'(sData), 0);
    check("R1 push rdValid", 32'(fValid), 0);
    check("R1 push empty", 32'(fEmpty), 1);
    check("R1 flags", 32'({sOvf, sUnf, fOvf, fUnf}), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2/R4: single word into empty, no read enable
    cycle(1, 0, 8'hA5);
    cycle(0, 0, 0);
    check("R2 pull no word without read", 32'(sValid), 0);
    check("R4 push word after second edge", 32'(fData), 32'hA5);
    check("R4 push valid after second edge", 32'(fValid), 1);
    repeat (3) cycle(0, 0, 0);
    // R3: pull read; R5: push acknowledge
    cycle(0, 1, 0);
    check("R3 pull data after read", 32'(sData), 32'hA5);
    check("R5 push drops valid when drained", 32'(fValid), 0);

    // R7/R8: fill past full
    for (int i = 0; i < D + 3; i++) begin
      cycle(1, 0, seq);
      seq++;
    end
    check("R8 pull overflow set", 32'(sOvf), 1);
    check("R7 push total capacity", 32'(fFull), 1);
    // R10: both enables at full
    cycle(1, 1, 8'hEE);
    // drain past empty, R6 order
    for (int i = 0; i < D + 4; i++) cycle(0, 1, 0);
    check("R9 pull underflow set", 32'(sUnf), 1);
    check("R9 push underflow set", 32'(fUnf), 1);
    // R10: both enables at empty
    cycle(1, 1, 8'h5C);
    cycle(0, 0, 0);
    cycle(0, 1, 0);
    check("R10 write kept at empty", 32'(sData), 32'h5C);

    // random streaming in varied densities
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 1500; i++) begin
        bit w, r;
        w = ($urandom_range(0, 3) < (p + 1));
        r = ($urandom_range(0, 3) < (4 - p)) ;
        cycle(w, r, DW'($urandom));
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule